// File: doc/BRIEF.md
# Edge Interrupt and Wakeup Detector

This block watches a bank of already-synchronized pin levels and turns selected transitions into interrupt and wakeup requests. Each pin compares its present level with the level it had one clock earlier. A low-to-high change counts as a rising edge and a high-to-low change counts as a falling edge. Two enable masks on the interrupt path, one for each edge direction, decide which transitions set sticky pending bits. Setting both masks on a pin gives detection on both edges. Only edges are detected; there is no level-sensitive trigger.

The pending bits are combined into one interrupt line toward a parent controller. A handler reads the pending word, services the lowest set bit, writes a one to that bit at the clear address, and reads the pending word again until it is zero. A new edge that arrives in the same cycle as the clear of its bit keeps the bit pending, so no event is lost.

A second, independent pair of edge masks feeds a wakeup output. That output is raised by a wake-enabled edge while the sleep flag is high and stays up until the sleep flag falls. All registers are reached through a simple single-cycle write port and a combinational read port.

Top module: `gpio_eirq_top`

## Requirements
- R1: After reset all four masks read 0, the pending word reads 0, and `irq_o` and `wake_o` are low. A pin that is already high when reset ends does not produce a pending bit once a rising mask is enabled afterwards.
- R2: Register map on `bus_addr`: 0 is the interrupt rising mask, 1 the interrupt falling mask, 2 the wake rising mask, 3 the wake falling mask, 4 the pending word (read only), and 5 the clear port (write only, reads 0). Bit n of each word belongs to pin n.
- R3: A 0-to-1 change on pin n, with bit n of the interrupt rising mask set, makes pending bit n read 1 at the first clock edge that samples the new level.
- R4: A 1-to-0 change on pin n, with bit n of the interrupt falling mask set, sets pending bit n in the same way. With both masks set, either direction sets the bit.
- R5: A transition whose interrupt mask bit for that direction is 0 leaves the pending word unchanged. Transitions on several pins in one cycle are captured independently.
- R6: Writing a word to address 5 clears exactly the pending bits where the word has ones; all other pending bits are kept. Writing to address 4 changes nothing.
- R7: When an enabled edge on pin n and a clear of bit n occur in the same cycle, pending bit n stays 1.
- R8: `irq_o` is high exactly when at least one pending bit is 1.
- R9: Writing a mask never sets or clears a pending bit; masks affect only edges seen after the write.
- R10: While `sleep_i` is high, an edge enabled by the wake masks raises `wake_o` one clock later and `wake_o` stays high while `sleep_i` stays high. `wake_o` is low one clock after `sleep_i` is low. Wake masks never set pending bits, and edges with `sleep_i` low never raise `wake_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_lvl_i | input | NPIN | Synchronized pin levels |
| sleep_i | input | 1 | Sleep flag enabling wakeup detection |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Read data for `bus_addr` |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Wakeup request |

## Verification
A wrong internal state shows up at the ports within one clock. A stale previous-level copy would make a false or missing pending bit at the next edge. A lost set or an over-wide clear would be visible as a wrong pending word on the very next read, and `irq_o` would follow it. A wrong wake flag would keep `wake_o` high one cycle after sleep ends, or keep it from rising one cycle after a wake edge. The checks therefore read the pending word and sample both outputs one clock after each stimulus. They target the same-cycle set and clear, partial clears, and mask writes made while bits are pending.

// File: rtl/gpio_eirq_pkg.sv
package gpio_eirq_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_IRQ_RISE  = 3'd0,
        A_IRQ_FALL  = 3'd1,
        A_WAKE_RISE = 3'd2,
        A_WAKE_FALL = 3'd3,
        A_PENDING   = 3'd4,
        A_CLEAR     = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/gpio_eirq_edge.sv
module gpio_eirq_edge #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] lvl_i,
    output logic [NPIN-1:0] rise_o,
    output logic [NPIN-1:0] fall_o
);
    logic [NPIN-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
        fall_o = ~lvl_i & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/gpio_eirq_cfg.sv
module gpio_eirq_cfg
    import gpio_eirq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPIN-1:0]   wdata,
    output logic [NPIN-1:0]   irq_rise_o,
    output logic [NPIN-1:0]   irq_fall_o,
    output logic [NPIN-1:0]   wake_rise_o,
    output logic [NPIN-1:0]   wake_fall_o
);
    typedef struct packed {
        logic [NPIN-1:0] irq_rise;
        logic [NPIN-1:0] irq_fall;
        logic [NPIN-1:0] wake_rise;
        logic [NPIN-1:0] wake_fall;
    } mask_t;

    mask_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (we) begin
            case (addr)
                A_IRQ_RISE:  m_d.irq_rise  = wdata;
                A_IRQ_FALL:  m_d.irq_fall  = wdata;
                A_WAKE_RISE: m_d.wake_rise = wdata;
                A_WAKE_FALL: m_d.wake_fall = wdata;
                default:     m_d = m_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign irq_rise_o  = m_q.irq_rise;
    assign irq_fall_o  = m_q.irq_fall;
    assign wake_rise_o = m_q.wake_rise;
    assign wake_fall_o = m_q.wake_fall;
endmodule

// File: rtl/gpio_eirq_top.sv
module gpio_eirq_top
    import gpio_eirq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_lvl_i,
    input  logic              sleep_i,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    output logic              irq_o,
    output logic              wake_o
);
    typedef struct packed {
        logic [NPIN-1:0] pending;
        logic            wake;
    } state_t;

    state_t s_d, s_q;

    logic [NPIN-1:0] rise, fall;
    logic [NPIN-1:0] irq_rise_m, irq_fall_m, wake_rise_m, wake_fall_m;
    logic [NPIN-1:0] set_vec, clr_vec;
    logic [NPIN-1:0] status_q;
    logic            wake_hit;

    gpio_eirq_edge #(.NPIN(NPIN)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pin_lvl_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    gpio_eirq_cfg #(.NPIN(NPIN)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (bus_we),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .irq_rise_o  (irq_rise_m),
        .irq_fall_o  (irq_fall_m),
        .wake_rise_o (wake_rise_m),
        .wake_fall_o (wake_fall_m)
    );

    always_comb begin
        set_vec  = (rise & irq_rise_m) | (fall & irq_fall_m);
        clr_vec  = (bus_we && bus_addr == A_CLEAR) ? bus_wdata : '0;
        wake_hit = |((rise & wake_rise_m) | (fall & wake_fall_m));

        s_d         = s_q;
        // a set in the same cycle as its clear keeps the bit pending
        s_d.pending = (s_q.pending & ~clr_vec) | set_vec;
        s_d.wake    = sleep_i & (s_q.wake | wake_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status_q = s_q.pending;

    always_comb begin
        case (bus_addr)
            A_IRQ_RISE:  bus_rdata = irq_rise_m;
            A_IRQ_FALL:  bus_rdata = irq_fall_m;
            A_WAKE_RISE: bus_rdata = wake_rise_m;
            A_WAKE_FALL: bus_rdata = wake_fall_m;
            A_PENDING:   bus_rdata = s_q.pending;
            default:     bus_rdata = '0;
        endcase
    end

    assign irq_o  = |s_q.pending;
    assign wake_o = s_q.wake;
endmodule

// File: rtl/gpio_eirq_chk.sv
module gpio_eirq_chk
    import gpio_eirq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_i,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPIN-1:0]   bus_wdata,
    input logic [NPIN-1:0]   set_vec,
    input logic [NPIN-1:0]   status_q,
    input logic              irq_o,
    input logic              wake_o
);
    // R7
    set_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

    // R9
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0) |=> ((status_q & ~$past(status_q)) == '0));

    // R6
    full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CLEAR && bus_wdata == '1 && set_vec == '0)
        |=> (status_q == '0 && !irq_o));

    // R10
    wake_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_i |=> !wake_o);

    // R10
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && sleep_i) |=> wake_o);
endmodule

bind gpio_eirq_top gpio_eirq_chk #(.NPIN(NPIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_i   (sleep_i),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .set_vec   (set_vec),
    .status_q  (status_q),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
);

// File: tb/tb_gpio_eirq_top.sv
`timescale 1ns/1ps
module tb_gpio_eirq_top;
    localparam int NPIN = 32;
    localparam int NVEC = 6;
    // entry: {rise mask, fall mask, level before, level after, expected pending}
    localparam logic [5*NPIN-1:0] VEC [NVEC] = '{
        {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_00F1, 32'h0000_00F1},
        {32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_0FFF, 32'h0000_F000},
        {32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_AAAA, 32'h0000_5555, 32'h0000_FFFF},
        {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
        {32'h8000_0001, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001},
        {32'h0000_0000, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0F0F_0F0F}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NPIN-1:0] pin_lvl_i = '0;
    logic            sleep_i = 1'b0;
    logic            bus_we = 1'b0;
    logic [2:0]      bus_addr = '0;
    logic [NPIN-1:0] bus_wdata = '0;
    logic [NPIN-1:0] bus_rdata;
    logic            irq_o, wake_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_eirq_top #(.NPIN(NPIN)) dut (.*);

    task automatic chk(input string tag, input logic [NPIN-1:0] act, input logic [NPIN-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [NPIN-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [NPIN-1:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic pins(input logic [NPIN-1:0] v);
        @(negedge clk);
        pin_lvl_i = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NPIN-1:0] r;
        pin_lvl_i = 32'h0000_0080;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[2:0], r); chk("R1 mask reset", r, '0);
        end
        rd(3'd4, r); chk("R1 pending reset", r, '0);
        chk("R1 irq reset", {31'b0, irq_o}, '0);
        chk("R1 wake reset", {31'b0, wake_o}, '0);
        wr(3'd0, '1);
        @(negedge clk);
        rd(3'd4, r); chk("R1 high-at-reset pin no pending", r, '0);
        rd(3'd0, r); chk("R2 rise mask readback", r, '1);

        // table walk: R3 R4 R5 R8
        for (int i = 0; i < NVEC; i++) begin
            pins(VEC[i][3*NPIN-1 -: NPIN]);
            wr(3'd0, VEC[i][5*NPIN-1 -: NPIN]);
            wr(3'd1, VEC[i][4*NPIN-1 -: NPIN]);
            wr(3'd5, '1);
            pins(VEC[i][2*NPIN-1 -: NPIN]);
            rd(3'd4, r); chk($sformatf("R3 R4 R5 vector %0d pending", i), r, VEC[i][NPIN-1:0]);
            chk($sformatf("R8 vector %0d irq", i), {31'b0, irq_o},
                {31'b0, (VEC[i][NPIN-1:0] != '0)});
        end

        // R6 partial clear, address 4 write ignored, clear address reads 0
        wr(3'd1, '0);
        wr(3'd0, 32'h0000_0011);
        wr(3'd5, '1);
        pins('0);
        pins(32'h0000_0011);
        wr(3'd4, '0);
        rd(3'd4, r); chk("R6 write to pending ignored", r, 32'h0000_0011);
        wr(3'd5, 32'h0000_0001);
        rd(3'd4, r); chk("R6 partial clear", r, 32'h0000_0010);
        chk("R8 irq with one bit", {31'b0, irq_o}, 1);
        rd(3'd5, r); chk("R2 clear address reads zero", r, '0);
        // R9 mask write keeps pending
        wr(3'd0, '0);
        rd(3'd4, r); chk("R9 mask off keeps pending", r, 32'h0000_0010);
        wr(3'd5, 32'h0000_0010);
        chk("R8 irq low after clear", {31'b0, irq_o}, 0);
        wr(3'd0, '1);
        rd(3'd4, r); chk("R9 mask on sets nothing", r, '0);

        // R7 set and clear in the same cycle
        pins('0);
        wr(3'd5, '1);
        @(negedge clk);
        pin_lvl_i = 32'h0000_0004;
        bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h0000_0004;
        @(negedge clk);
        bus_we = 1'b0;
        rd(3'd4, r); chk("R7 set wins over clear", r, 32'h0000_0004);

        // R10 wakeup
        wr(3'd0, '0);
        wr(3'd5, '1);
        pins('0);
        wr(3'd2, 32'h0000_0008);
        pins(32'h0000_0008);
        chk("R10 no wake while awake", {31'b0, wake_o}, 0);
        pins('0);
        @(negedge clk);
        sleep_i = 1'b1;
        pins(32'h0000_0008);
        chk("R10 wake raised", {31'b0, wake_o}, 1);
        rd(3'd4, r); chk("R10 wake mask sets no pending", r, '0);
        pins('0);
        chk("R10 wake held", {31'b0, wake_o}, 1);
        @(negedge clk);
        sleep_i = 1'b0;
        @(negedge clk);
        chk("R10 wake drops with sleep", {31'b0, wake_o}, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule